// File: doc/BRIEF.md
# Debug Run Control with Hardware Breakpoints

This block sits beside a small 8-bit microcontroller core and gives an external debugger control over its execution. The debugger reaches it through a register port with three strobes. One latches an 8-bit register address. One writes 8-bit data to the latched address. One reads 8-bit data from the latched address. The serial link that carries these strobes, and the core itself, are outside the block. The core is seen only through its fetch program counter, its status word, and a halt output.

The core comes out of reset halted. Before execution can be resumed, the debugger must unlock run control by writing two keys in sequence to the control register. After that, a resume code starts the core. While the core runs, its fetch address is compared against four breakpoint registers. An enabled match halts the core, captures the program counter and status word into copy registers, and drives a 3-cycle active-low pulse on the hit line so the debugger learns of the stop. The debugger can also stop a running core at any time with a strobe on the host stop input. That stop produces no pulse.

Top module: `dbg_runctl`

## Requirements
- R1: Out of reset `core_halt` is 1, `hit_pulse_n` is 1, run control is locked and all breakpoints are disabled.
- R2: A read of address 0x00 returns the parameter DEV_ID (default 0x0D). A read of address 0x01 returns 0x00.
- R3: Run control unlocks only when 0x02 and then 0x01 are written to the control register at 0x02 on consecutive control writes. Any other value, or the keys in the other order, leaves it locked.
- R4: Writing 0x08 to 0x02 while unlocked and halted clears `core_halt` on the clock edge that takes the data write.
- R5: Writing 0x08 to 0x02 while locked, or while the core is already running, has no effect on `core_halt`.
- R6: Breakpoint n uses a low/high register pair: 0x85/0x86, 0xAB/0xAC, 0xCE/0xCF and 0xD2/0xD3 for n = 0..3. The low register holds the enable in bit 7 and address bits 14:8 in bits 6:0. The high register holds address bits 7:0. Both registers read back what was written.
- R7: While running, if `core_pc[14:0]` equals an enabled breakpoint address, `core_halt` rises on the next edge. `core_pc[15]` takes no part in the compare. A disabled breakpoint never matches.
- R8: Writing 0x00 to a breakpoint's low register disables that breakpoint.
- R9: A breakpoint halt drives `hit_pulse_n` low for exactly 3 cycles, starting in the first halted cycle. The pulse appears only while halted.
- R10: A one-cycle `host_stop` while running sets `core_halt` on the next edge, with no pulse. While halted, `host_stop` has no effect.
- R11: On entering halt, `core_pc` and `core_psw` from the cycle before are captured. While halted they read at 0x20 (PC low byte), 0x21 (PC high byte) and 0x23 (status). While running these addresses read 0x00.
- R12: A data read loads `host_rdata` on its clock edge from the register at the latched address, and the address stays latched across accesses. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr_we | input | 1 | Latch `host_wdata` as register address |
| host_data_we | input | 1 | Write `host_wdata` to the latched address |
| host_data_re | input | 1 | Load `host_rdata` from the latched address |
| host_wdata | input | 8 | Address or data from the debugger |
| host_rdata | output | 8 | Read data, valid after the read edge |
| host_stop | input | 1 | Debugger stop strobe |
| hit_pulse_n | output | 1 | Active-low breakpoint hit pulse |
| core_pc | input | 16 | Core fetch program counter |
| core_psw | input | 8 | Core status word |
| core_halt | output | 1 | Holds the core stopped when 1 |

## Verification
A wrong key-sequence state shows up at the next resume attempt: the core either starts when it should not, or stays halted. A corrupted breakpoint register shows up in the cycle after the matching fetch address is presented: the halt arrives early, late, or never, or the captured PC copy differs from the programmed address. A wrong pulse counter changes the low width seen on `hit_pulse_n` within three cycles of the halt. A capture fault is visible at the first read of 0x20, 0x21 or 0x23 after the stop.

// File: rtl/dbg_pkg.sv
// Shared constants and types for the debug run-control block.
// Assumes at most four breakpoints, since only four register pairs are mapped.
package dbg_pkg;
    localparam logic [7:0] A_DEVID = 8'h00;
    localparam logic [7:0] A_REVID = 8'h01;
    localparam logic [7:0] A_CTRL  = 8'h02;
    localparam logic [7:0] A_PCL   = 8'h20;
    localparam logic [7:0] A_PCH   = 8'h21;
    localparam logic [7:0] A_PSW   = 8'h23;

    localparam logic [7:0] KEY_FIRST  = 8'h02;
    localparam logic [7:0] KEY_SECOND = 8'h01;
    localparam logic [7:0] CMD_RESUME = 8'h08;

    typedef enum logic [1:0] {LK_LOCKED, LK_KEY1, LK_OPEN} lock_state_e;
    typedef enum logic {ST_HALT, ST_RUN} run_state_e;

    // Low-register address of breakpoint i; the high register is the next address.
    function automatic logic [7:0] bp_lo_addr(input int i);
        case (i)
            0:       return 8'h85;
            1:       return 8'hAB;
            2:       return 8'hCE;
            default: return 8'hD2;
        endcase
    endfunction
endpackage

// File: rtl/dbg_keylock.sv
// Two-key unlock sequencer for run control.
// Assumes ctrl_we is a one-cycle strobe for each write to the control register.
// Once open, it stays open until reset.
module dbg_keylock
    import dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] wdata,
    output logic       unlocked
);
    lock_state_e state_q;

    // Advance the key sequence on each control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LK_LOCKED;
        else if (ctrl_we && state_q != LK_OPEN) begin
            if (state_q == LK_KEY1 && wdata == KEY_SECOND)
                state_q <= LK_OPEN;
            else if (wdata == KEY_FIRST)
                state_q <= LK_KEY1;
            else
                state_q <= LK_LOCKED;
        end
    end

    // Expose the open state.
    assign unlocked = (state_q == LK_OPEN);

    // R3
    key_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(ctrl_we && wdata == KEY_SECOND));
endmodule

// File: rtl/dbg_bp_bank.sv
// Bank of hardware breakpoint register pairs and their fetch-address compare.
// Assumes a 15-bit compare address: the low register holds {enable, addr[14:8]},
// and the high register holds addr[7:0].
module dbg_bp_bank
    import dbg_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int CMP_W  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       wdata,
    input  logic [CMP_W-1:0] pc,
    output logic             match,
    output logic [7:0]       rd_data
);
    localparam int HI_W = CMP_W - 8;

    logic [NUM_BP-1:0] en_q;
    logic [CMP_W-1:0]  adr_q [NUM_BP];
    logic [NUM_BP-1:0] hit_vec;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        localparam logic [7:0] LO = bp_lo_addr(g);
        localparam logic [7:0] HI = LO + 8'd1;

        // Register writes to this breakpoint pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g]  <= 1'b0;
                adr_q[g] <= '0;
            end else if (reg_we && reg_addr == LO) begin
                en_q[g]             <= wdata[7];
                adr_q[g][CMP_W-1:8] <= wdata[HI_W-1:0];
            end else if (reg_we && reg_addr == HI) begin
                adr_q[g][7:0] <= wdata;
            end
        end

        // Compare the fetch address with this breakpoint.
        assign hit_vec[g] = en_q[g] && (pc == adr_q[g]);

        // R8
        bp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == LO && wdata == 8'h00) |=> !hit_vec[g]);
    end

    assign match = |hit_vec;

    // Read mux over all breakpoint registers; zero when no pair is addressed.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_BP; i++) begin
            if (reg_addr == bp_lo_addr(i))
                rd_data = {en_q[i], adr_q[i][CMP_W-1:8]};
            else if (reg_addr == bp_lo_addr(i) + 8'd1)
                rd_data = adr_q[i][7:0];
        end
    end
endmodule

// File: rtl/dbg_halt_ctl.sv
// Run/halt state machine with state capture and the hit pulse generator.
// Assumes resume_req and host_stop are one-cycle strobes.
// A breakpoint halt pulses hit_pulse_n; a host stop does not.
module dbg_halt_ctl
    import dbg_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int PULSE_CYC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            unlocked,
    input  logic            resume_req,
    input  logic            bp_match,
    input  logic            host_stop,
    input  logic [PC_W-1:0] core_pc,
    input  logic [7:0]      core_psw,
    output logic            core_halt,
    output logic            hit_pulse_n,
    output logic [PC_W-1:0] pc_copy,
    output logic [7:0]      psw_copy
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    run_state_e       state_q;
    logic [CNT_W-1:0] pulse_cnt_q;
    logic             stop_now;

    assign stop_now = (state_q == ST_RUN) && (bp_match || host_stop);

    // Move between run and halt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_HALT;
        else if (stop_now)
            state_q <= ST_HALT;
        else if (state_q == ST_HALT && resume_req && unlocked)
            state_q <= ST_RUN;
    end

    // Capture the core state as execution stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_copy  <= '0;
            psw_copy <= '0;
        end else if (stop_now) begin
            pc_copy  <= core_pc;
            psw_copy <= core_psw;
        end
    end

    // Time the hit pulse after a breakpoint stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_cnt_q <= '0;
        else if (state_q == ST_RUN && bp_match)
            pulse_cnt_q <= CNT_W'(PULSE_CYC);
        else if (pulse_cnt_q != '0)
            pulse_cnt_q <= pulse_cnt_q - 1'b1;
    end

    assign core_halt   = (state_q == ST_HALT);
    assign hit_pulse_n = (pulse_cnt_q == '0);

    // Checker: length of the current low run on the hit line.
    logic [CNT_W:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run_q <= '0;
        else if (!hit_pulse_n && low_run_q != '1)
            low_run_q <= low_run_q + 1'b1;
        else if (hit_pulse_n)
            low_run_q <= '0;
    end

    // R4 R5
    resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_halt) |-> $past(unlocked && resume_req));
    // R7
    bp_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && bp_match) |=> (core_halt && !hit_pulse_n));
    // R9
    pulse_in_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_pulse_n |-> core_halt);
    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_pulse_n) |-> (low_run_q == (CNT_W+1)'(PULSE_CYC)));
    // R10
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && host_stop && !bp_match) |=> (core_halt && hit_pulse_n));
    // R11
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_halt) |-> (pc_copy == $past(core_pc) && psw_copy == $past(core_psw)));
endmodule

// File: rtl/dbg_runctl.sv
// Top level of the debug run controller: host register port, address decode
// and read mux around the key lock, breakpoint bank and halt controller.
// Assumes the host strobes are synchronous one-cycle pulses in the clk domain.
module dbg_runctl
    import dbg_pkg::*;
#(
    parameter logic [7:0] DEV_ID    = 8'h0D,
    parameter int         NUM_BP    = 4,
    parameter int         PULSE_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_addr_we,
    input  logic        host_data_we,
    input  logic        host_data_re,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        host_stop,
    output logic        hit_pulse_n,
    input  logic [15:0] core_pc,
    input  logic [7:0]  core_psw,
    output logic        core_halt
);
    localparam int PC_W  = 16;
    localparam int CMP_W = PC_W - 1;

    logic [7:0]      addr_q;
    logic            ctrl_we;
    logic            unlocked;
    logic            bp_match;
    logic [7:0]      bp_rd;
    logic [PC_W-1:0] pc_copy;
    logic [7:0]      psw_copy;
    logic [7:0]      rd_mux;

    // Latch the register address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= 8'h00;
        else if (host_addr_we)
            addr_q <= host_wdata;
    end

    assign ctrl_we = host_data_we && (addr_q == A_CTRL);

    dbg_keylock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .wdata    (host_wdata),
        .unlocked (unlocked)
    );

    dbg_bp_bank #(.NUM_BP(NUM_BP), .CMP_W(CMP_W)) u_bp (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (host_data_we),
        .reg_addr (addr_q),
        .wdata    (host_wdata),
        .pc       (core_pc[CMP_W-1:0]),
        .match    (bp_match),
        .rd_data  (bp_rd)
    );

    dbg_halt_ctl #(.PC_W(PC_W), .PULSE_CYC(PULSE_CYC)) u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .unlocked    (unlocked),
        .resume_req  (ctrl_we && host_wdata == CMD_RESUME),
        .bp_match    (bp_match),
        .host_stop   (host_stop),
        .core_pc     (core_pc),
        .core_psw    (core_psw),
        .core_halt   (core_halt),
        .hit_pulse_n (hit_pulse_n),
        .pc_copy     (pc_copy),
        .psw_copy    (psw_copy)
    );

    // Select read data for the latched address.
    always_comb begin
        case (addr_q)
            A_DEVID: rd_mux = DEV_ID;
            A_REVID: rd_mux = 8'h00;
            A_PCL:   rd_mux = core_halt ? pc_copy[7:0]  : 8'h00;
            A_PCH:   rd_mux = core_halt ? pc_copy[15:8] : 8'h00;
            A_PSW:   rd_mux = core_halt ? psw_copy      : 8'h00;
            default: rd_mux = bp_rd;
        endcase
    end

    // Register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= 8'h00;
        else if (host_data_re)
            host_rdata <= rd_mux;
    end

    // R1
    reset_halt_chk: assert property (@(posedge clk)
        !rst_n |=> (core_halt && hit_pulse_n));
    // R2
    devid_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_re && addr_q == A_DEVID) |=> host_rdata == DEV_ID);
endmodule

// File: tb/dbg_runctl_bench.sv
// Self-checking bench: directed corner cases, then seeded random breakpoint runs.
module dbg_runctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_addr_we = 1'b0, host_data_we = 1'b0, host_data_re = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        host_stop = 1'b0;
    logic        hit_pulse_n;
    logic [15:0] core_pc = 16'h0000;
    logic [7:0]  core_psw = 8'h00;
    logic        core_halt;

    int checks = 0;
    int errors = 0;

    // Bench model of the breakpoint registers.
    bit          m_en  [4];
    logic [14:0] m_adr [4];

    always #10 clk = ~clk;

    dbg_runctl u_dbg_runctl (
        .clk(clk), .rst_n(rst_n),
        .host_addr_we(host_addr_we), .host_data_we(host_data_we),
        .host_data_re(host_data_re), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_stop(host_stop),
        .hit_pulse_n(hit_pulse_n), .core_pc(core_pc),
        .core_psw(core_psw), .core_halt(core_halt)
    );

    function automatic logic [7:0] lo_of(input int i);
        case (i)
            0: return 8'h85;
            1: return 8'hAB;
            2: return 8'hCE;
            default: return 8'hD2;
        endcase
    endfunction

    function automatic bit model_match(input logic [15:0] pc);
        for (int i = 0; i < 4; i++)
            if (m_en[i] && m_adr[i] == pc[14:0]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_addr(input logic [7:0] a);
        @(negedge clk); host_addr_we = 1'b1; host_wdata = a;
        @(negedge clk); host_addr_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d);
        @(negedge clk); host_data_we = 1'b1; host_wdata = d;
        @(negedge clk); host_data_we = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        wr_addr(a);
        wr_data(d);
    endtask

    task automatic rd_data(output logic [7:0] d);
        @(negedge clk); host_data_re = 1'b1;
        @(negedge clk); host_data_re = 1'b0;
        d = host_rdata;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        wr_addr(a);
        rd_data(d);
    endtask

    task automatic set_bp(input int i, input bit en, input logic [14:0] adr);
        wr_reg(lo_of(i), {en, adr[14:8]});
        wr_reg(lo_of(i) + 8'd1, adr[7:0]);
        m_en[i]  = en;
        m_adr[i] = adr;
    endtask

    // Present a PC; the design reacts on the next edge, sampled at the next negedge.
    task automatic step_pc(input logic [15:0] pc, input logic [7:0] psw);
        @(negedge clk); core_pc = pc; core_psw = psw;
        @(negedge clk);
    endtask

    // Width of the low pulse starting at the current negedge.
    task automatic pulse_width(output int w);
        w = 0;
        while (!hit_pulse_n && w < 10) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic host_stop_pulse;
        @(negedge clk); host_stop = 1'b1;
        @(negedge clk); host_stop = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] pc;
        logic [7:0]  psw;
        int          w;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin m_en[i] = 1'b0; m_adr[i] = '0; end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(core_halt == 1'b1, "R1 halt", {15'd0, core_halt}, 16'd1);
        chk(hit_pulse_n == 1'b1, "R1 pulse", {15'd0, hit_pulse_n}, 16'd1);
        rd_reg(8'h85, d);
        chk(d == 8'h00, "R1 bp disabled", {8'd0, d}, 16'h00);

        // R2 identification
        rd_reg(8'h00, d);
        chk(d == 8'h0D, "R2 devid", {8'd0, d}, 16'h0D);
        rd_data(d);
        chk(d == 8'h0D, "R12 address held", {8'd0, d}, 16'h0D);
        rd_reg(8'h01, d);
        chk(d == 8'h00, "R2 revid", {8'd0, d}, 16'h00);
        rd_reg(8'h50, d);
        chk(d == 8'h00, "R12 unmapped", {8'd0, d}, 16'h00);

        // R5 resume while locked
        wr_reg(8'h02, 8'h08);
        chk(core_halt == 1'b1, "R5 locked resume", {15'd0, core_halt}, 16'd1);

        // R3 wrong orders stay locked
        wr_data(8'h01); wr_data(8'h02); wr_data(8'h08);
        chk(core_halt == 1'b1, "R3 reversed keys", {15'd0, core_halt}, 16'd1);
        wr_data(8'h02); wr_data(8'h05); wr_data(8'h01); wr_data(8'h08);
        chk(core_halt == 1'b1, "R3 broken sequence", {15'd0, core_halt}, 16'd1);

        // R3 correct unlock
        wr_data(8'h02); wr_data(8'h01);

        // R6 breakpoint layout and readback
        set_bp(0, 1'b1, 15'h1234);
        rd_reg(8'h85, d);
        chk(d == 8'h92, "R6 bp0 low", {8'd0, d}, 16'h92);
        rd_reg(8'h86, d);
        chk(d == 8'h34, "R6 bp0 high", {8'd0, d}, 16'h34);

        // R4 resume
        core_pc = 16'h0000;
        wr_reg(8'h02, 8'h08);
        chk(core_halt == 1'b0, "R4 resume", {15'd0, core_halt}, 16'd0);
        wr_data(8'h08);
        chk(core_halt == 1'b0, "R5 resume while running", {15'd0, core_halt}, 16'd0);
        rd_reg(8'h20, d);
        chk(d == 8'h00, "R11 copy while running", {8'd0, d}, 16'h00);

        // R7 R9 hit with PC bit 15 set
        step_pc(16'h9234, 8'hA5);
        chk(core_halt == 1'b1, "R7 bp hit", {15'd0, core_halt}, 16'd1);
        pulse_width(w);
        chk(w == 3, "R9 pulse width", w[15:0], 16'd3);
        rd_reg(8'h20, d);
        chk(d == 8'h34, "R11 pc low", {8'd0, d}, 16'h34);
        rd_reg(8'h21, d);
        chk(d == 8'h92, "R11 pc high", {8'd0, d}, 16'h92);
        rd_reg(8'h23, d);
        chk(d == 8'hA5, "R11 psw", {8'd0, d}, 16'hA5);

        // R8 clear breakpoint
        wr_reg(8'h85, 8'h00); m_en[0] = 1'b0;
        rd_reg(8'h85, d);
        chk(d == 8'h00, "R8 cleared readback", {8'd0, d}, 16'h00);
        wr_reg(8'h02, 8'h08);
        step_pc(16'h1234, 8'h11);
        step_pc(16'h1234, 8'h11);
        chk(core_halt == 1'b0, "R8 cleared no hit", {15'd0, core_halt}, 16'd0);

        // R10 host stop while running: halt, no pulse
        host_stop_pulse();
        chk(core_halt == 1'b1, "R10 stop halts", {15'd0, core_halt}, 16'd1);
        chk(hit_pulse_n == 1'b1, "R10 no pulse", {15'd0, hit_pulse_n}, 16'd1);
        rd_reg(8'h21, d);
        chk(d == 8'h12, "R11 stop capture", {8'd0, d}, 16'h12);
        host_stop_pulse();
        chk(core_halt == 1'b1 && hit_pulse_n == 1'b1, "R10 stop while halted",
            {14'd0, core_halt, hit_pulse_n}, 16'd3);

        // R7 disabled breakpoint never matches
        set_bp(2, 1'b0, 15'h0456);
        rd_reg(8'hCE, d);
        chk(d == 8'h04, "R6 bp2 low", {8'd0, d}, 16'h04);
        wr_reg(8'h02, 8'h08);
        step_pc(16'h0456, 8'h00);
        chk(core_halt == 1'b0, "R7 disabled", {15'd0, core_halt}, 16'd0);
        host_stop_pulse();

        // Random breakpoint runs
        for (int it = 0; it < 24; it++) begin
            int idx;
            logic [14:0] adr;
            idx = int'($urandom_range(0, 3));
            adr = 15'($urandom);
            for (int i = 0; i < 4; i++) if (i != idx && m_en[i]) begin
                wr_reg(lo_of(i), 8'h00); m_en[i] = 1'b0;
            end
            set_bp(idx, 1'b1, adr);
            rd_reg(lo_of(idx), d);
            chk(d == {1'b1, adr[14:8]}, "R6 random low", {8'd0, d}, {8'd0, 1'b1, adr[14:8]});
            do pc = 16'($urandom); while (model_match(pc));
            core_pc = pc;
            wr_reg(8'h02, 8'h08);
            for (int k = 0; k < int'($urandom_range(1, 5)); k++) begin
                do pc = 16'($urandom); while (model_match(pc));
                step_pc(pc, 8'($urandom));
                chk(core_halt == 1'b0, "R7 random miss", {15'd0, core_halt}, 16'd0);
            end
            pc  = {1'($urandom), adr};
            psw = 8'($urandom);
            step_pc(pc, psw);
            chk(core_halt == 1'b1, "R7 random hit", {15'd0, core_halt}, 16'd1);
            pulse_width(w);
            chk(w == 3, "R9 random width", w[15:0], 16'd3);
            rd_reg(8'h20, d);
            chk(d == pc[7:0], "R11 random pcl", {8'd0, d}, {8'd0, pc[7:0]});
            rd_reg(8'h21, d);
            chk(d == pc[15:8], "R11 random pch", {8'd0, d}, {8'd0, pc[15:8]});
            rd_reg(8'h23, d);
            chk(d == psw, "R11 random psw", {8'd0, d}, {8'd0, psw});
        end

        summary();
        $finish;
    end
endmodule